// File: doc/BRIEF.md
# Harmonic Digital Down Converter

The block receives a stream of 16-bit signed converter samples, one per clock, together with a 32-bit phase word from a synthesizer that tracks the revolution frequency. It multiplies that phase by a chosen harmonic number. The product steers a sine/cosine generator that mixes the selected harmonic down to baseband I and Q at the full sample rate. A third-order integrator-comb filter then decimates the two streams by a run-time power of two. The outputs are 24-bit I/Q words, with a strobe that marks each new output pair.

An automatic gain stage watches the peak sample magnitude over fixed windows. When the converter range is poorly used, it asks the analog front end for 18 dB more gain, and it backs off again when the signal grows large. The thresholds for these two moves are separate, which gives hysteresis. Whenever the high-gain setting is active, the decimated I/Q words are shifted down by the matching factor of 8. This keeps the reported amplitude continuous across a gain switch. One channel is built here; a multi-channel receiver instantiates it once per input.

Top module: `harmonic_ddc`

## Requirements
- R1: The mixer phase is the reference phase multiplied by the 5-bit harmonic select, taken modulo 2^32. Its upper 12 bits form the generator address A.
- R2: The sine value is sgn * ((k*(2048-k)) >> 6), where k = A mod 2048 and sgn is negative when bit 11 of A is set. The cosine value is the sine value at address (A+1024) mod 4096.
- R3: The mixer forms I = sample * cosine and Q = sample * sine at full precision.
- R4: The filter is a third-order integrator-comb that decimates by 2^L. L is the 4-bit ratio select: values below 3 act as 3 and values above 8 act as 8. The DC gain of the filter is exactly (2^L)^3.
- R5: Each output word is the filter result arithmetically shifted right by 3L+6+3g and kept as 24 bits signed, where g is the gain state. For a settled constant input, the output equals (sample*cosine) >>> (6+3g) for I and (sample*sine) >>> (6+3g) for Q.
- R6: The valid strobe is high for exactly one cycle per 2^L input samples.
- R7: Each window is 4096 samples long and tracks the peak absolute sample value. At the end of a window, low gain (g=0) switches to high gain when the peak is below the low threshold. High gain (g=1) switches back to low gain when the peak is above the high threshold.
- R8: The gain state changes only at window ends. A peak lying between the two thresholds leaves it unchanged.
- R9: With high gain, the I/Q outputs are a factor of 8 (3 bits) smaller than with low gain for the same samples.
- R10: A synchronous reset clears the valid strobe, the outputs, the gain state and all filter state. After reset, a zero input produces zero outputs from the first strobe on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| adc_in | input | 16 | Signed converter sample |
| ref_phase | input | 32 | Revolution-locked reference phase |
| harm_sel | input | 5 | Harmonic number |
| dec_log2 | input | 4 | Decimation exponent L |
| thr_hi | input | 16 | Peak level above which high gain is dropped |
| thr_lo | input | 16 | Peak level below which high gain is engaged |
| i_out | output | 24 | Decimated in-phase word |
| q_out | output | 24 | Decimated quadrature word |
| out_valid | output | 1 | One-cycle strobe per output pair |
| gain_hi | output | 1 | Front-end gain request, 1 = +18 dB |

## Verification
Several faults show up at the I/Q outputs within a few output strobes after a constant input settles. These are a wrong phase product, a wrong address slice, or a wrong table value, and they appear as a wrong steady value. A miscounted decimation counter shows up as a wrong spacing between strobes. A stuck or misused gain state shows up in two places: the gain output, one or two windows (up to about 8200 cycles) after the input level moves, and an I/Q word off by a factor of 8. Integrator or comb state left over from before a reset appears as non-zero output on the first strobes after the reset.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
    localparam int SMP_W      = 16;
    localparam int PH_W       = 32;
    localparam int HARM_W     = 5;
    localparam int ADDR_W     = 12;
    localparam int TRIG_W     = 16;
    localparam int MIX_W      = 32;
    localparam int N_STG      = 3;
    localparam int LSEL_W     = 4;
    localparam int L_MIN      = 3;
    localparam int L_MAX      = 8;
    localparam int CIC_W      = MIX_W + N_STG * L_MAX;
    localparam int OUT_W      = 24;
    localparam int NORM_SH    = 6;
    localparam int GAIN_SH    = 3;
    localparam int HALF_PER   = 1 << (ADDR_W - 1);
    localparam int QTR_PER    = 1 << (ADDR_W - 2);

    typedef enum logic {GAIN_LO = 1'b0, GAIN_HI = 1'b1} gain_e;

    typedef struct packed {
        logic signed [MIX_W-1:0] i;
        logic signed [MIX_W-1:0] q;
    } iq_mix_t;

    // parabolic half-wave: magnitude k*(2*QTR-k) scaled, sign from top address bit
    function automatic logic signed [TRIG_W-1:0] half_wave(input logic [ADDR_W-1:0] a);
        logic [2*ADDR_W-1:0] k;
        logic [2*ADDR_W-1:0] prod;
        logic signed [TRIG_W-1:0] mag;
        k    = {{(ADDR_W+1){1'b0}}, a[ADDR_W-2:0]};
        prod = k * ((2*ADDR_W)'(HALF_PER) - k);
        mag  = $signed(prod[NORM_SH +: TRIG_W]);
        return a[ADDR_W-1] ? -mag : mag;
    endfunction
endpackage

// File: rtl/ddc_mixer.sv
module ddc_mixer
    import ddc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SMP_W-1:0] smp,
    input  logic [PH_W-1:0]         ref_ph,
    input  logic [HARM_W-1:0]       harm,
    output iq_mix_t                 mix
);
    logic [PH_W-1:0]          ph;
    logic [ADDR_W-1:0]        addr;
    logic signed [TRIG_W-1:0] sn, cs;
    logic signed [MIX_W-1:0]  sx, snx, csx;

    always_comb begin
        ph   = ref_ph * {{(PH_W-HARM_W){1'b0}}, harm};
        addr = ph[PH_W-1 -: ADDR_W];
        sn   = half_wave(addr);
        cs   = half_wave(addr + ADDR_W'(QTR_PER));
        sx   = MIX_W'(smp);
        snx  = MIX_W'(sn);
        csx  = MIX_W'(cs);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mix <= '0;
        end else begin
            mix.i <= sx * csx;
            mix.q <= sx * snx;
        end
    end

    // R2
    trig_range_chk: assert property (@(posedge clk) disable iff (rst)
        (cs <= 16'sd16384 && cs >= -16'sd16384 && sn <= 16'sd16384 && sn >= -16'sd16384));

    // R3
    zero_mix_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(smp) == '0) |-> (mix.i == '0 && mix.q == '0));
endmodule

// File: rtl/ddc_cic.sv
module ddc_cic
    import ddc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [MIX_W-1:0] din,
    input  logic [LSEL_W-1:0]       lsel,
    input  gain_e                   gain,
    output logic signed [OUT_W-1:0] dout,
    output logic                    vld
);
    localparam int CNT_W = L_MAX;

    logic [LSEL_W-1:0]       l_eff;
    logic [CNT_W-1:0]        cnt, last;
    logic                    take;
    logic signed [CIC_W-1:0] integ [N_STG];
    logic signed [CIC_W-1:0] dly   [N_STG];
    logic signed [CIC_W-1:0] cin   [N_STG];
    logic signed [CIC_W-1:0] comb_out;
    int                      sh;

    always_comb begin
        if (lsel < LSEL_W'(L_MIN))      l_eff = LSEL_W'(L_MIN);
        else if (lsel > LSEL_W'(L_MAX)) l_eff = LSEL_W'(L_MAX);
        else                            l_eff = lsel;
        last = CNT_W'((32'd1 << l_eff) - 32'd1);
        take = (cnt >= last);
        sh   = 3 * int'(l_eff) + NORM_SH + ((gain == GAIN_HI) ? GAIN_SH : 0);
    end

    always_comb begin
        logic signed [CIC_W-1:0] acc;
        acc = integ[N_STG-1];
        for (int g = 0; g < N_STG; g++) begin
            cin[g] = acc;
            acc    = acc - dly[g];
        end
        comb_out = acc;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int g = 0; g < N_STG; g++) begin
                integ[g] <= '0;
                dly[g]   <= '0;
            end
            cnt  <= '0;
            vld  <= 1'b0;
            dout <= '0;
        end else begin
            integ[0] <= integ[0] + CIC_W'(din);
            for (int g = 1; g < N_STG; g++) integ[g] <= integ[g] + integ[g-1];
            cnt <= take ? '0 : cnt + 1'b1;
            vld <= take;
            if (take) begin
                for (int g = 0; g < N_STG; g++) dly[g] <= cin[g];
                dout <= OUT_W'(comb_out >>> sh);
            end
        end
    end

    // R6
    vld_single_chk: assert property (@(posedge clk) disable iff (rst) vld |=> !vld);

    // R10
    flush_chk: assert property (@(posedge clk) rst |=> (!vld && dout == '0));
endmodule

// File: rtl/ddc_agc.sv
module ddc_agc
    import ddc_pkg::*;
#(
    parameter int WIN = 4096
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic signed [SMP_W-1:0] smp,
    input  logic [SMP_W-1:0]        thr_hi,
    input  logic [SMP_W-1:0]        thr_lo,
    output gain_e                   gain
);
    localparam int WC_W = $clog2(WIN);

    logic [WC_W-1:0]  wcnt;
    logic [SMP_W-1:0] mag, run_pk, pk_fin;
    logic             win_end;

    always_comb begin
        mag     = smp[SMP_W-1] ? (~smp + 1'b1) : smp;
        pk_fin  = (mag > run_pk) ? mag : run_pk;
        win_end = (wcnt == WC_W'(WIN - 1));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt   <= '0;
            run_pk <= '0;
            gain   <= GAIN_LO;
        end else begin
            wcnt   <= win_end ? '0 : wcnt + 1'b1;
            run_pk <= win_end ? '0 : pk_fin;
            if (win_end) begin
                unique case (gain)
                    GAIN_LO: if (pk_fin < thr_lo) gain <= GAIN_HI;
                    GAIN_HI: if (pk_fin > thr_hi) gain <= GAIN_LO;
                endcase
            end
        end
    end

    // R8
    gain_edge_chk: assert property (@(posedge clk) disable iff (rst)
        (gain != $past(gain)) |-> $past(win_end));

    // R7
    gain_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (gain == GAIN_HI && $past(gain) == GAIN_LO) |-> ($past(pk_fin) < $past(thr_lo)));

    // R7
    gain_fall_chk: assert property (@(posedge clk) disable iff (rst)
        (gain == GAIN_LO && $past(gain) == GAIN_HI) |-> ($past(pk_fin) > $past(thr_hi)));
endmodule

// File: rtl/harmonic_ddc.sv
module harmonic_ddc
    import ddc_pkg::*;
#(
    parameter int WIN = 4096
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [SMP_W-1:0]     adc_in,
    input  logic [PH_W-1:0]      ref_phase,
    input  logic [HARM_W-1:0]    harm_sel,
    input  logic [LSEL_W-1:0]    dec_log2,
    input  logic [SMP_W-1:0]     thr_hi,
    input  logic [SMP_W-1:0]     thr_lo,
    output logic [OUT_W-1:0]     i_out,
    output logic [OUT_W-1:0]     q_out,
    output logic                 out_valid,
    output logic                 gain_hi
);
    iq_mix_t                 mix;
    gain_e                   gain;
    logic signed [OUT_W-1:0] i_w, q_w;
    logic                    vi, vq;

    ddc_mixer u_mix (
        .clk(clk), .rst(rst), .smp($signed(adc_in)),
        .ref_ph(ref_phase), .harm(harm_sel), .mix(mix)
    );

    ddc_agc #(.WIN(WIN)) u_agc (
        .clk(clk), .rst(rst), .smp($signed(adc_in)),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .gain(gain)
    );

    ddc_cic u_cic_i (
        .clk(clk), .rst(rst), .din(mix.i), .lsel(dec_log2),
        .gain(gain), .dout(i_w), .vld(vi)
    );

    ddc_cic u_cic_q (
        .clk(clk), .rst(rst), .din(mix.q), .lsel(dec_log2),
        .gain(gain), .dout(q_w), .vld(vq)
    );

    assign i_out     = i_w;
    assign q_out     = q_w;
    assign out_valid = vi;
    assign gain_hi   = (gain == GAIN_HI);

    // R6
    iq_align_chk: assert property (@(posedge clk) disable iff (rst) vi == vq);
endmodule

// File: tb/tb_harmonic_ddc.sv
module tb_harmonic_ddc;
    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] adc_in;
    logic [31:0] ref_phase;
    logic [4:0]  harm_sel;
    logic [3:0]  dec_log2;
    logic [15:0] thr_hi, thr_lo;
    logic [23:0] i_out, q_out;
    logic        out_valid, gain_hi;

    int total = 0;
    int bad   = 0;
    longint cyc = 0;

    harmonic_ddc dut (
        .clk(clk), .rst(rst), .adc_in(adc_in), .ref_phase(ref_phase),
        .harm_sel(harm_sel), .dec_log2(dec_log2), .thr_hi(thr_hi), .thr_lo(thr_lo),
        .i_out(i_out), .q_out(q_out), .out_valid(out_valid), .gain_hi(gain_hi)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        wait (cyc > 190000);
        bad++; total++;
        $display("FAIL watchdog: actual=%0d cycles expected<190000", cyc);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic chk(input string req, input longint act, input longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint trig(input longint a);
        longint k, m;
        k = a % 2048;
        m = (k * (2048 - k)) / 64;
        return (a >= 2048) ? -m : m;
    endfunction

    function automatic longint expect_iq(input longint x, input logic [31:0] r,
                                         input logic [4:0] h, input bit quad, input int g);
        longint ph, a, t;
        ph = (longint'(r) * longint'(h)) % 64'sd4294967296;
        a  = ph / 64'sd1048576;
        t  = quad ? trig(a) : trig((a + 1024) % 4096);
        return (x * t) >>> (6 + 3 * g);
    endfunction

    // returns cycle of strobe, or -1 on timeout
    task automatic wait_valid(output longint at);
        at = -1;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            if (out_valid) begin
                at = cyc;
                return;
            end
        end
        bad++; total++;
        $display("FAIL R6: actual=no strobe expected=strobe");
    endtask

    task automatic run_dc(input logic signed [15:0] x, input logic [31:0] r,
                          input logic [4:0] h, input logic [3:0] l, input int g);
        longint t0, t1;
        int le;
        @(negedge clk);
        adc_in = x; ref_phase = r; harm_sel = h; dec_log2 = l;
        for (int n = 0; n < 6; n++) wait_valid(t0);
        wait_valid(t1);
        le = (l < 3) ? 3 : (l > 8) ? 8 : l;
        // R6 strobe spacing 2^L
        chk("R6", t1 - t0, longint'(1) << le);
        // R1 R2 R3 R4 R5 settled value
        chk("R5", longint'($signed(i_out)), expect_iq(x, r, h, 1'b0, g));
        chk("R5", longint'($signed(q_out)), expect_iq(x, r, h, 1'b1, g));
    endtask

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; adc_in = '0; ref_phase = '0; harm_sel = '0; dec_log2 = 4'd3;
        thr_hi = 16'hFFFF; thr_lo = 16'h0000;
        repeat (4) @(negedge clk);
        // R10 reset state
        chk("R10", out_valid, 0);
        chk("R10", i_out, 0);
        chk("R10", gain_hi, 0);
        rst = 1'b0;

        // R2 R3 phase zero: full-scale cosine, zero sine
        run_dc(16'sd32767, 32'h0, 5'd0, 4'd3, 0);
        chk("R2", longint'($signed(i_out)), 64'sd8388352);
        run_dc(-16'sd32768, 32'h0, 5'd1, 4'd4, 0);
        chk("R5", longint'($signed(i_out)), -64'sd8388608);
        // R1 modular wrap of phase product
        run_dc(16'sd20000, 32'hFFFF_FFFF, 5'd31, 4'd5, 0);
        run_dc(16'sd12345, 32'h4000_0000, 5'd1, 4'd8, 0);
        // R4 ratio clamping
        run_dc(16'sd7000, 32'h1234_5678, 5'd3, 4'd0, 0);
        run_dc(-16'sd7000, 32'h1234_5678, 5'd3, 4'd15, 0);
        // constrained random
        for (int n = 0; n < 14; n++) begin
            run_dc(16'($urandom), $urandom, 5'($urandom), 4'(3 + $urandom % 6), 0);
        end

        // R7 low peak engages high gain
        @(negedge clk);
        thr_lo = 16'd1000; thr_hi = 16'd20000; adc_in = 16'sd500;
        repeat (2 * 4096 + 8) @(negedge clk);
        chk("R7", gain_hi, 1);
        // R9 outputs scaled down by 8
        run_dc(16'sd500, 32'h0, 5'd0, 4'd3, 1);
        run_dc(16'sd900, 32'h2000_0000, 5'd2, 4'd6, 1);
        // R8 peak between thresholds holds high gain
        @(negedge clk);
        adc_in = 16'sd10000;
        repeat (2 * 4096 + 8) @(negedge clk);
        chk("R8", gain_hi, 1);
        // R7 large peak drops gain
        adc_in = -16'sd30000;
        repeat (2 * 4096 + 8) @(negedge clk);
        chk("R7", gain_hi, 0);
        // R8 between thresholds holds low gain
        adc_in = 16'sd10000;
        repeat (2 * 4096 + 8) @(negedge clk);
        chk("R8", gain_hi, 0);
        run_dc(16'sd10000, 32'h0, 5'd0, 4'd3, 0);

        // R10 flush: filter state cleared by reset
        thr_lo = 16'h0000; thr_hi = 16'hFFFF;
        run_dc(16'sd30000, 32'h0, 5'd0, 4'd8, 0);
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10", out_valid, 0);
        chk("R10", i_out, 0);
        adc_in = '0;
        rst = 1'b0;
        begin
            longint t;
            wait_valid(t);
            chk("R10", longint'($signed(i_out)), 0);
            wait_valid(t);
            chk("R10", longint'($signed(i_out)), 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule